// File: doc/BRIEF.md
# GPIO Bank with Sleep-State Retention

This block is a bank of general-purpose I/O pins. For every pin it holds a direction bit, an output latch that is changed by write-one set and write-one clear pulses, a synchronised level readback, separate rising and falling edge enables that feed a sticky edge status bit, and a 2-bit alternate-function select. The select either passes the GPIO latch to the pin or passes one of three peripheral output sources. It also returns the pin level to the peripheral input that matches the select. The direction register alone decides whether a pin is driven, whatever the select.

When the sleep request rises, a separately programmed sleep value is copied into the output latches, and the bank begins to drive it. The bank also snapshots the sleep value and the directions. After the request drops, the pins keep those frozen values until software has made at least one programming write (direction, set or clear) and then acknowledges with the re-init pulse. While the request is high, an enabled edge on one of the low wake-capable pins produces a one-cycle wake pulse. Pin 0 is kept for sleep use and can never take an alternate function.

Top module: `gpio_sleep_bank`

## Requirements
- R1: After reset, pin_out, pin_oe, edge_status, wake and hold_active are all 0.
- R2: Two clock edges after a pulse, pin_out shows the output latch. The latch takes latch & ~clr_pulse | set_pulse, so set wins when both hit a bit, and zero bits leave the latch unchanged.
- R3: pin_oe follows the direction register (dir_wdata stored on dir_we) two edges after the write, also for pins with a non-zero alternate select.
- R4: The select for pin i is alt_wdata[2i+1:2i]. A value of 0 outputs the latch. A value s in 1..3 outputs periph_out[(s-1)*NPINS+i], and periph_in[(s-1)*NPINS+i] carries level[i]. Every periph_in bit whose select does not match is 0.
- R5: Pin 0 ignores any alternate select. Its output is always the latch, and its three periph_in bits stay 0.
- R6: level[i] follows pin_in[i] through two synchroniser flops, so a change before edge 1 shows after edge 2.
- R7: A rise (when rise enable is set) or a fall (when fall enable is set) of the synchronised level sets edge_status one edge after level changes. The bit stays set until edge_clr writes 1 to it. A new edge in the same cycle as the clear wins.
- R8: On a rising sleep_req, the sleep value is loaded into the latch. From the second edge on, pin_out shows it, pin_oe shows the directions at entry, and hold_active is 1.
- R9: While hold_active is set, writes change no pin. The hold ends only on reinit_ack when sleep_req is low and a programming write came after wake. A lone reinit_ack leaves it set. After release, the pins show the updated latch.
- R10: wake pulses one cycle, with status, when sleep_req is high and an enabled edge hits a pin below WAKE_PINS. Pins at or above WAKE_PINS, and edges while awake, give no wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_we | input | 1 | Direction register write strobe |
| dir_wdata | input | NPINS | Direction value, 1 = output |
| set_pulse | input | NPINS | Write-one set of the output latch |
| clr_pulse | input | NPINS | Write-one clear of the output latch |
| rise_en_we | input | 1 | Rising-edge enable write strobe |
| rise_en_wdata | input | NPINS | Rising-edge enables |
| fall_en_we | input | 1 | Falling-edge enable write strobe |
| fall_en_wdata | input | NPINS | Falling-edge enables |
| edge_clr | input | NPINS | Write-one clear of edge status |
| alt_we | input | 1 | Alternate-select write strobe |
| alt_wdata | input | 2*NPINS | Alternate selects, 2 bits per pin |
| sleep_val_we | input | 1 | Sleep value write strobe |
| sleep_val_wdata | input | NPINS | Value to drive during sleep |
| sleep_req | input | 1 | High while the system sleeps |
| reinit_ack | input | 1 | Pulse: software has re-initialised the bank |
| pin_in | input | NPINS | Pad input levels |
| periph_out | input | 3*NPINS | Peripheral output sources, NPINS bits each |
| pin_out | output | NPINS | Pad output values (registered) |
| pin_oe | output | NPINS | Pad output enables (registered) |
| periph_in | output | 3*NPINS | Pin levels routed to peripheral inputs |
| level | output | NPINS | Synchronised pin level |
| edge_status | output | NPINS | Sticky edge status |
| wake | output | 1 | Wake-up pulse |
| hold_active | output | 1 | Sleep values frozen on the pins |

## Verification
A lost or wrongly loaded retention snapshot appears on pin_out and pin_oe two edges after the sleep request rises. It persists until reinit_ack releases it, so a single sample after entry and another after wake expose it. A release that comes early or late shows on hold_active, and on the pins two edges later. A broken synchroniser or status register changes level or edge_status within three edges of a pin change. A bad select decode shows on pin_out or periph_in as soon as the select register is written.

// File: rtl/gpio_sleep_pkg.sv
package gpio_sleep_pkg;
  localparam int unsigned NUM_SRC = 3;
  typedef enum logic [1:0] {
    ALT_GPIO = 2'd0,
    ALT_SRC0 = 2'd1,
    ALT_SRC1 = 2'd2,
    ALT_SRC2 = 2'd3
  } alt_sel_e;
endpackage

// File: rtl/gpio_edge_unit.sv
// Two-flop synchroniser, edge detect and sticky status for all pins.
module gpio_edge_unit #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] rise_en,
  input  logic [NPINS-1:0] fall_en,
  input  logic [NPINS-1:0] edge_clr,
  output logic [NPINS-1:0] level,
  output logic [NPINS-1:0] edge_status,
  output logic [NPINS-1:0] edge_hit
);
  logic [NPINS-1:0] sync1_q, sync2_q, prev_q, stat_q;

  assign edge_hit = (sync2_q & ~prev_q & rise_en) | (~sync2_q & prev_q & fall_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      stat_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      // a fresh edge takes priority over a clear of the same bit
      stat_q  <= (stat_q & ~edge_clr) | edge_hit;
    end
  end

  assign level       = sync2_q;
  assign edge_status = stat_q;
endmodule

// File: rtl/gpio_retention_ctl.sv
// Sleep entry snapshot and the hold that keeps it on the pins after wake.
module gpio_retention_ctl #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_req,
  input  logic             reinit_ack,
  input  logic             prog_write,
  input  logic [NPINS-1:0] sleep_val,
  input  logic [NPINS-1:0] dir_cur,
  output logic             entry,
  output logic             hold_active,
  output logic [NPINS-1:0] hold_val,
  output logic [NPINS-1:0] hold_dir
);
  logic sleep_d, reprog_q, hold_q;

  assign entry = sleep_req & ~sleep_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sleep_d  <= 1'b0;
      reprog_q <= 1'b0;
      hold_q   <= 1'b0;
      hold_val <= '0;
      hold_dir <= '0;
    end else begin
      sleep_d <= sleep_req;
      if (entry) begin
        hold_val <= sleep_val;
        hold_dir <= dir_cur;
        hold_q   <= 1'b1;
        reprog_q <= 1'b0;
      end else if (hold_q && !sleep_req) begin
        if (prog_write) reprog_q <= 1'b1;
        if (reinit_ack && reprog_q) hold_q <= 1'b0;
      end
    end
  end

  assign hold_active = hold_q;
endmodule

// File: rtl/gpio_pin_mux.sv
// Per-pin output selection and peripheral input routing.
module gpio_pin_mux
  import gpio_sleep_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic                     hold_active,
  input  logic [NPINS-1:0]         hold_val,
  input  logic [NPINS-1:0]         hold_dir,
  input  logic [NPINS-1:0]         out_q,
  input  logic [NPINS-1:0]         dir_q,
  input  logic [NPINS-1:0]         level,
  input  logic [2*NPINS-1:0]       alt_q,
  input  logic [NUM_SRC*NPINS-1:0] periph_out,
  output logic [NPINS-1:0]         out_d,
  output logic [NPINS-1:0]         oe_d,
  output logic [NUM_SRC*NPINS-1:0] periph_in
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    alt_sel_e sel;
    logic     src;
    // pin 0 is reserved and always behaves as plain GPIO
    assign sel = (i == 0) ? ALT_GPIO : alt_sel_e'(alt_q[2*i +: 2]);

    always_comb begin
      case (sel)
        ALT_SRC0: src = periph_out[i];
        ALT_SRC1: src = periph_out[NPINS + i];
        ALT_SRC2: src = periph_out[2*NPINS + i];
        default:  src = out_q[i];
      endcase
      out_d[i] = hold_active ? hold_val[i] : src;
      oe_d[i]  = hold_active ? hold_dir[i] : dir_q[i];
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      assign periph_in[k*NPINS + i] = level[i] & (sel == alt_sel_e'(2'(k + 1)));
    end
  end
endmodule

// File: rtl/gpio_sleep_bank.sv
module gpio_sleep_bank
  import gpio_sleep_pkg::*;
#(
  parameter int unsigned NPINS     = 32,
  parameter int unsigned WAKE_PINS = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     dir_we,
  input  logic [NPINS-1:0]         dir_wdata,
  input  logic [NPINS-1:0]         set_pulse,
  input  logic [NPINS-1:0]         clr_pulse,
  input  logic                     rise_en_we,
  input  logic [NPINS-1:0]         rise_en_wdata,
  input  logic                     fall_en_we,
  input  logic [NPINS-1:0]         fall_en_wdata,
  input  logic [NPINS-1:0]         edge_clr,
  input  logic                     alt_we,
  input  logic [2*NPINS-1:0]       alt_wdata,
  input  logic                     sleep_val_we,
  input  logic [NPINS-1:0]         sleep_val_wdata,
  input  logic                     sleep_req,
  input  logic                     reinit_ack,
  input  logic [NPINS-1:0]         pin_in,
  input  logic [NUM_SRC*NPINS-1:0] periph_out,
  output logic [NPINS-1:0]         pin_out,
  output logic [NPINS-1:0]         pin_oe,
  output logic [NUM_SRC*NPINS-1:0] periph_in,
  output logic [NPINS-1:0]         level,
  output logic [NPINS-1:0]         edge_status,
  output logic                     wake,
  output logic                     hold_active
);
  localparam int unsigned WAKE_N = (WAKE_PINS < NPINS) ? WAKE_PINS : NPINS;

  logic [NPINS-1:0]   dir_q, out_q, rise_q, fall_q, sleep_val_q;
  logic [2*NPINS-1:0] alt_q;
  logic [NPINS-1:0]   edge_hit, hold_val, hold_dir, out_d, oe_d;
  logic               entry, prog_write, wake_q;

  assign prog_write = dir_we | (|set_pulse) | (|clr_pulse);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q       <= '0;
      out_q       <= '0;
      rise_q      <= '0;
      fall_q      <= '0;
      sleep_val_q <= '0;
      alt_q       <= '0;
    end else begin
      if (dir_we)       dir_q       <= dir_wdata;
      if (rise_en_we)   rise_q      <= rise_en_wdata;
      if (fall_en_we)   fall_q      <= fall_en_wdata;
      if (alt_we)       alt_q       <= alt_wdata;
      if (sleep_val_we) sleep_val_q <= sleep_val_wdata;
      if (entry) out_q <= sleep_val_q;
      else       out_q <= (out_q & ~clr_pulse) | set_pulse;
    end
  end

  gpio_edge_unit #(.NPINS(NPINS)) edge_i (
    .clk(clk), .rst(rst), .pin_in(pin_in), .rise_en(rise_q), .fall_en(fall_q),
    .edge_clr(edge_clr), .level(level), .edge_status(edge_status), .edge_hit(edge_hit)
  );

  gpio_retention_ctl #(.NPINS(NPINS)) ret_i (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .reinit_ack(reinit_ack),
    .prog_write(prog_write), .sleep_val(sleep_val_q), .dir_cur(dir_q),
    .entry(entry), .hold_active(hold_active), .hold_val(hold_val), .hold_dir(hold_dir)
  );

  gpio_pin_mux #(.NPINS(NPINS)) mux_i (
    .hold_active(hold_active), .hold_val(hold_val), .hold_dir(hold_dir),
    .out_q(out_q), .dir_q(dir_q), .level(level), .alt_q(alt_q),
    .periph_out(periph_out), .out_d(out_d), .oe_d(oe_d), .periph_in(periph_in)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
      wake_q  <= 1'b0;
    end else begin
      pin_out <= out_d;
      pin_oe  <= oe_d;
      wake_q  <= sleep_req & (|edge_hit[WAKE_N-1:0]);
    end
  end

  assign wake = wake_q;
endmodule

// File: rtl/gpio_sleep_bank_chk.sv
module gpio_sleep_bank_chk #(
  parameter int unsigned NPINS = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               sleep_req,
  input logic               reinit_ack,
  input logic [NPINS-1:0]   edge_clr,
  input logic [NPINS-1:0]   pin_out,
  input logic [NPINS-1:0]   pin_oe,
  input logic [3*NPINS-1:0] periph_in,
  input logic [NPINS-1:0]   edge_status,
  input logic               wake,
  input logic               hold_active
);
  AST_PIN0_NO_PERIPH: assert property (@(posedge clk) disable iff (rst)
    (periph_in[0] == 1'b0) && (periph_in[NPINS] == 1'b0) && (periph_in[2*NPINS] == 1'b0)); // R5

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(edge_status) & ~$past(edge_clr) & ~edge_status) == '0); // R7

  AST_HOLD_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep_req) |=> hold_active); // R8

  AST_SLEEP_STABLE: assert property (@(posedge clk) disable iff (rst)
    (sleep_req && $past(sleep_req) && $past(sleep_req, 2) && $past(sleep_req, 3))
      |-> ($stable(pin_out) && $stable(pin_oe))); // R8

  AST_HOLD_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_active) |-> ($past(reinit_ack) && !$past(sleep_req))); // R9

  AST_WAKE_IN_SLEEP: assert property (@(posedge clk) disable iff (rst)
    wake |-> $past(sleep_req)); // R10
endmodule

bind gpio_sleep_bank gpio_sleep_bank_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst(rst), .sleep_req(sleep_req), .reinit_ack(reinit_ack),
  .edge_clr(edge_clr), .pin_out(pin_out), .pin_oe(pin_oe), .periph_in(periph_in),
  .edge_status(edge_status), .wake(wake), .hold_active(hold_active)
);

// File: tb/gpio_sleep_bank_tb.sv
`timescale 1ns/1ps
module gpio_sleep_bank_tb_top;
  localparam int N = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic dir_we = 0, rise_en_we = 0, fall_en_we = 0, alt_we = 0, sleep_val_we = 0;
  logic sleep_req = 0, reinit_ack = 0;
  logic [N-1:0] dir_wdata = '0, set_pulse = '0, clr_pulse = '0;
  logic [N-1:0] rise_en_wdata = '0, fall_en_wdata = '0, edge_clr = '0;
  logic [N-1:0] sleep_val_wdata = '0, pin_in = '0;
  logic [2*N-1:0] alt_wdata = '0;
  logic [3*N-1:0] periph_out = '0;
  logic [N-1:0] pin_out, pin_oe, level, edge_status;
  logic [3*N-1:0] periph_in;
  logic wake, hold_active;

  int compared = 0, mismatched = 0, wake_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_sleep_bank dut_i (
    .clk(clk), .rst(rst), .dir_we(dir_we), .dir_wdata(dir_wdata),
    .set_pulse(set_pulse), .clr_pulse(clr_pulse),
    .rise_en_we(rise_en_we), .rise_en_wdata(rise_en_wdata),
    .fall_en_we(fall_en_we), .fall_en_wdata(fall_en_wdata), .edge_clr(edge_clr),
    .alt_we(alt_we), .alt_wdata(alt_wdata),
    .sleep_val_we(sleep_val_we), .sleep_val_wdata(sleep_val_wdata),
    .sleep_req(sleep_req), .reinit_ack(reinit_ack), .pin_in(pin_in),
    .periph_out(periph_out), .pin_out(pin_out), .pin_oe(pin_oe),
    .periph_in(periph_in), .level(level), .edge_status(edge_status),
    .wake(wake), .hold_active(hold_active)
  );

  always @(posedge clk) if (wake === 1'b1) wake_cnt <= wake_cnt + 1;

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3*N-1:0] act, input logic [3*N-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    check("R1 pin_out", pin_out, 0);
    check("R1 pin_oe", pin_oe, 0);
    check("R1 edge_status", edge_status, 0);
    check("R1 wake", wake, 0);
    check("R1 hold_active", hold_active, 0);
  endtask

  task automatic t_set_clr();
    dir_we = 1; dir_wdata = '1; step(); dir_we = 0;
    set_pulse = 32'h0000_00F0; step(); set_pulse = '0; step();
    check("R2 set", pin_out, 32'h0000_00F0);
    set_pulse = 32'h0000_0300; clr_pulse = 32'h0000_0130; step();
    set_pulse = '0; clr_pulse = '0; step();
    check("R2 set wins over clear", pin_out, 32'h0000_03C0);
    step(3);
    check("R2 zero writes ignored", pin_out, 32'h0000_03C0);
  endtask

  task automatic t_dir_alt();
    dir_we = 1; dir_wdata = 32'h0000_00FF; step(); dir_we = 0; step();
    check("R3 direction", pin_oe, 32'h0000_00FF);
    // pin4 sel 2, pin5 sel 1, pin6 sel 3
    alt_wdata = '0;
    alt_wdata[9:8] = 2'd2; alt_wdata[11:10] = 2'd1; alt_wdata[13:12] = 2'd3;
    alt_we = 1;
    periph_out = {32'h0000_0000, 32'h0000_0010, 32'h0000_0020};
    pin_in = 32'h0000_0070;
    step(); alt_we = 0; step(3);
    check("R4 alt output", pin_out, 32'h0000_03B0);
    check("R3 direction with alt", pin_oe, 32'h0000_00FF);
    check("R4 periph_in routing", periph_in, {32'h0000_0040, 32'h0000_0010, 32'h0000_0020});
  endtask

  task automatic t_pin0();
    alt_wdata[1:0] = 2'd1; alt_we = 1;
    periph_out = {32'h0000_0001, 32'h0000_0001, 32'h0000_0001};
    pin_in = 32'h0000_0001;
    step(); alt_we = 0; step(3);
    check("R5 pin0 output", pin_out[0], 0);
    check("R5 pin0 periph_in", {periph_in[2*N], periph_in[N], periph_in[0]}, 0);
    alt_wdata = '0; alt_we = 1; periph_out = '0; pin_in = '0;
    step(); alt_we = 0; step(3);
    check("R4 back to GPIO", pin_out, 32'h0000_03C0);
  endtask

  task automatic t_edges();
    rise_en_wdata = 32'h0000_0100; rise_en_we = 1;
    fall_en_wdata = 32'h0000_0200; fall_en_we = 1;
    step(); rise_en_we = 0; fall_en_we = 0;
    pin_in[8] = 1; step();
    check("R6 level not yet", level[8], 0);
    step();
    check("R6 level after two edges", level[8], 1);
    step();
    check("R7 rise detected", edge_status, 32'h0000_0100);
    pin_in[9] = 1; step(4);
    check("R7 rise without enable", edge_status, 32'h0000_0100);
    pin_in[9] = 0; step(4);
    check("R7 fall detected, sticky", edge_status, 32'h0000_0300);
    edge_clr = 32'h0000_0100; step(); edge_clr = '0; step();
    check("R7 write-one clear", edge_status, 32'h0000_0200);
    pin_in[8] = 0; step(4);
    pin_in[8] = 1; step(2);
    edge_clr = 32'h0000_0100; step(); edge_clr = '0;
    check("R7 edge wins over clear", edge_status, 32'h0000_0300);
    edge_clr = '1; step(); edge_clr = '0; step();
    check("R7 clear all", edge_status, 0);
  endtask

  task automatic t_sleep();
    sleep_val_wdata = 32'h0000_0A5A; sleep_val_we = 1; step(); sleep_val_we = 0;
    sleep_req = 1; step(2);
    check("R8 sleep value driven", pin_out, 32'h0000_0A5A);
    check("R8 directions kept", pin_oe, 32'h0000_00FF);
    check("R8 hold set", hold_active, 1);
    sleep_req = 0; step(3);
    check("R9 hold after wake", pin_out, 32'h0000_0A5A);
    reinit_ack = 1; step(); reinit_ack = 0; step(2);
    check("R9 lone ack ignored", hold_active, 1);
    set_pulse = 32'h0000_0001; step(); set_pulse = '0; step(2);
    check("R9 write frozen", pin_out, 32'h0000_0A5A);
    reinit_ack = 1; step(); reinit_ack = 0;
    check("R9 release", hold_active, 0);
    step();
    check("R9 latch shown after release", pin_out, 32'h0000_0A5B);
  endtask

  task automatic t_wake();
    int base;
    rise_en_wdata = 32'h0001_0008; rise_en_we = 1; step(); rise_en_we = 0;
    sleep_req = 1; step(2);
    base = wake_cnt;
    pin_in[16] = 1; step(6);
    check("R10 high pin no wake", wake_cnt - base, 0);
    pin_in[3] = 1; step(6);
    check("R10 wake pulse", wake_cnt - base, 1);
    sleep_req = 0; pin_in[3] = 0; step(4);
    pin_in[3] = 1; step(6);
    check("R10 no wake while awake", wake_cnt - base, 1);
  endtask

  initial begin
    step(3); rst = 0; step();
    t_reset();
    t_set_clr();
    t_dir_alt();
    t_pin0();
    t_edges();
    t_sleep();
    t_wake();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule